// File: doc/BRIEF.md
# Receive descriptor ring DMA

This block takes frames from a byte stream and places them in memory buffers. A ring of four-word descriptors in memory lists those buffers. For each frame the engine reads the next descriptor, which gives a buffer address and a capacity. It packs the bytes into 32-bit words, writes them through a word-wide memory request port, and then writes back the descriptor with the stored length and the done and last-segment flags set.

Software and the engine share the ring through a release index. At start-up software sets that index to one below the ring size, which hands every slot but one to the engine. The engine never fills the slot whose index equals the release index. When it reaches that slot it holds the stream with ready low until software moves the index. Software clears done and writes the slot's index to return a slot. A small register window holds the ring base, ring size, release index, current index, enable, busy and an index clear.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, s_ready and mem_req are low, the current index reads 0 and the control register reads 0.
- R2: Register offsets: ring base 0x100, ring size 0x104, release index 0x108, current index 0x10C (read-only), control 0x204, index clear 0x208. Control bit 2 is the enable, bit 3 is busy (read-only) and bits 5:4 are a stored burst code. Read data appears in the cycle after reg_rd.
- R3: The descriptor of slot k sits at ring base + 16*k. The engine reads word 0 (buffer address) and then word 1 at +4, whose bits 29:16 give the buffer capacity in bytes.
- R4: Byte 4j+i of a frame goes to bits 8i+7:8i of the word at buffer address + 4j. Lanes of the final word that no stored byte reaches are written as 0.
- R5: The write-back to word 1 carries done in bit 31, last-segment in bit 30, the stored byte count in bits 29:16 and zero in bits 15:14, and it keeps the fetched bits 13:0.
- R6: Bytes past the capacity are accepted and dropped, and no write goes past the capacity. The written length is then the capacity.
- R7: A frame never starts in the slot equal to the release index. While that holds, s_ready stays low and no memory request is made.
- R8: After each write-back the current index advances by one and wraps to 0 when it reaches the ring size.
- R9: Busy reads 1 from the first descriptor read until the write-back is granted. Clearing enable in the middle of a frame still lets that frame complete.
- R10: With enable low and the engine idle, no frame starts and s_ready stays low.
- R11: Writing 0x208 with bit 16 set returns the current index to 0. A write there with bit 16 clear changes nothing.
- R12: A memory request holds mem_req, mem_we and mem_addr steady until mem_gnt. Read data is taken on mem_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the frame |
| s_ready | output | 1 | Engine accepts the byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Several properties are checked on every cycle. A pending memory request must not change until it is granted. A frame may start only in a slot other than the release index. The index may only step by one or return to zero, and an idle engine with enable low must stay idle. A dropped byte must not raise the stored count, and the written-back length must stay within the capacity. Other behaviour depends on a whole frame or on a sequence of register writes, and only the bench scenarios show it: the byte lanes and zero fill of partial words, the preserved low bits of word 1, the wrap of the index, a frame finishing after enable is cleared, and the release of a stalled stream when the release index moves.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int LEN_W = 14;          // capacity / length field width
  localparam int CAP_LO = 16;         // capacity field low bit in word 1
  localparam int WORD_BYTES = 4;

  localparam logic [11:0] OFS_BASE   = 12'h100;
  localparam logic [11:0] OFS_COUNT  = 12'h104;
  localparam logic [11:0] OFS_REL    = 12'h108;
  localparam logic [11:0] OFS_CUR    = 12'h10C;
  localparam logic [11:0] OFS_CTRL   = 12'h204;
  localparam logic [11:0] OFS_IDXCLR = 12'h208;

  localparam int CTRL_EN_BIT   = 2;
  localparam int CTRL_BUSY_BIT = 3;
  localparam int IDXCLR_BIT    = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD0W, ST_RD1, ST_RD1W, ST_DATA, ST_WORD, ST_WB
  } rxr_state_e;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic              busy,
  output logic [ADDR_W-1:0] ring_base,
  output logic [IDX_W-1:0]  ring_cnt,
  output logic [IDX_W-1:0]  rel_idx,
  output logic              rx_en,
  output logic              idx_clr
);
  logic [1:0]  burst_q;
  logic [31:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_base <= '0;
      ring_cnt  <= '0;
      rel_idx   <= '0;
      rx_en     <= 1'b0;
      burst_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_BASE:  ring_base <= reg_wdata[ADDR_W-1:0];
        OFS_COUNT: ring_cnt  <= reg_wdata[IDX_W-1:0];
        OFS_REL:   rel_idx   <= reg_wdata[IDX_W-1:0];
        OFS_CTRL: begin
          rx_en   <= reg_wdata[CTRL_EN_BIT];
          burst_q <= reg_wdata[5:4];
        end
        default: ;
      endcase
    end
  end

  assign idx_clr = reg_wr && (reg_addr == OFS_IDXCLR) && reg_wdata[IDXCLR_BIT];

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_BASE:  rd_mux[ADDR_W-1:0] = ring_base;
      OFS_COUNT: rd_mux[IDX_W-1:0]  = ring_cnt;
      OFS_REL:   rd_mux[IDX_W-1:0]  = rel_idx;
      OFS_CUR:   rd_mux[IDX_W-1:0]  = cur_idx;
      OFS_CTRL: begin
        rd_mux[CTRL_EN_BIT]   = rx_en;
        rd_mux[CTRL_BUSY_BIT] = busy;
        rd_mux[5:4]           = burst_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;
endmodule

// File: rtl/rxr_pack.sv
module rxr_pack
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             take,
  input  logic             drain,
  input  logic [7:0]       din,
  input  logic [LEN_W-1:0] cap,
  output logic             keep,
  output logic [1:0]       lane,
  output logic [LEN_W-1:0] count,
  output logic [31:0]      word
);
  logic [7:0] lane_q [WORD_BYTES];

  assign keep = count < cap;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lane  <= '0;
      count <= '0;
    end else if (take && keep) begin
      lane  <= lane + 2'd1;
      count <= count + 1'b1;
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr || drain)
        lane_q[g] <= '0;
      else if (take && keep && lane == 2'(g))
        lane_q[g] <= din;
    end
    assign word[8*g +: 8] = lane_q[g];
  end

  AST_DROP_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (take && !keep && !clr) |=> $stable(count)); // R6
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [IDX_W-1:0]  ring_cnt,
  input  logic [IDX_W-1:0]  rel_idx,
  input  logic              idx_clr,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              pk_keep,
  input  logic [1:0]        pk_lane,
  input  logic [LEN_W-1:0]  pk_count,
  input  logic [31:0]       pk_word,
  output logic              pk_clr,
  output logic              pk_take,
  output logic              pk_drain,
  output logic [LEN_W-1:0]  cap_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              busy
);
  rxr_state_e        state_q;
  logic [ADDR_W-1:0] desc_q, waddr_q;
  logic [LEN_W-1:0]  low_q;
  logic              last_q;
  logic              slot_free, accept, store, go_word, go_wb;
  logic [1:0]        lane_after;
  logic [IDX_W:0]    inc;
  logic [IDX_W-1:0]  idx_next;

  assign slot_free  = cur_idx != rel_idx;
  assign accept     = (state_q == ST_DATA) && s_valid;
  assign store      = accept && pk_keep;
  assign lane_after = pk_lane + {1'b0, store};
  assign go_word    = (store && pk_lane == 2'd3) || (accept && s_last && lane_after != 2'd0);
  assign go_wb      = accept && s_last && !go_word;
  assign inc        = {1'b0, cur_idx} + 1'b1;
  assign idx_next   = (inc >= {1'b0, ring_cnt}) ? '0 : inc[IDX_W-1:0];

  assign s_ready  = state_q == ST_DATA;
  assign busy     = state_q != ST_IDLE;
  assign pk_clr   = state_q == ST_IDLE;
  assign pk_take  = accept;
  assign pk_drain = (state_q == ST_WORD) && mem_gnt;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_q;
    mem_wdata = '0;
    case (state_q)
      ST_RD0: mem_req = 1'b1;
      ST_RD1: begin mem_req = 1'b1; mem_addr = desc_q + ADDR_W'(4); end
      ST_WORD: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = waddr_q; mem_wdata = pk_word;
      end
      ST_WB: begin
        mem_req   = 1'b1; mem_we = 1'b1; mem_addr = desc_q + ADDR_W'(4);
        mem_wdata = {2'b11, pk_count, 2'b00, low_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      waddr_q <= '0;
      cap_q   <= '0;
      low_q   <= '0;
      last_q  <= 1'b0;
      cur_idx <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (rx_en && slot_free && s_valid && !idx_clr) begin
          desc_q  <= ring_base + ADDR_W'({cur_idx, 4'h0});
          state_q <= ST_RD0;
        end
        ST_RD0:  if (mem_gnt) state_q <= ST_RD0W;
        ST_RD0W: if (mem_rvalid) begin
          waddr_q <= mem_rdata[ADDR_W-1:0];
          state_q <= ST_RD1;
        end
        ST_RD1:  if (mem_gnt) state_q <= ST_RD1W;
        ST_RD1W: if (mem_rvalid) begin
          cap_q   <= mem_rdata[CAP_LO +: LEN_W];
          low_q   <= mem_rdata[LEN_W-1:0];
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (go_word) begin
            last_q  <= s_last;
            state_q <= ST_WORD;
          end else if (go_wb) begin
            state_q <= ST_WB;
          end
        end
        ST_WORD: if (mem_gnt) begin
          waddr_q <= waddr_q + ADDR_W'(4);
          state_q <= last_q ? ST_WB : ST_DATA;
        end
        ST_WB: if (mem_gnt) begin
          cur_idx <= idx_next;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (idx_clr) cur_idx <= '0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
  AST_NO_OWNED_SLOT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(cur_idx) != $past(rel_idx))); // R7
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!busy && !rx_en) |=> !busy); // R10
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_idx) |-> (cur_idx == '0 || cur_idx == $past(cur_idx) + 1'b1)); // R8
  AST_WB_LEN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WB) |-> (pk_count <= cap_q)); // R6
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);
  logic [ADDR_W-1:0] ring_base;
  logic [IDX_W-1:0]  ring_cnt, rel_idx, cur_idx;
  logic              rx_en, idx_clr, busy;
  logic              pk_keep, pk_clr, pk_take, pk_drain;
  logic [1:0]        pk_lane;
  logic [LEN_W-1:0]  pk_count, cap;
  logic [31:0]       pk_word;

  rxr_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .cur_idx, .busy, .ring_base, .ring_cnt, .rel_idx, .rx_en, .idx_clr
  );

  rxr_pack u_pack (
    .clk, .rst, .clr(pk_clr), .take(pk_take), .drain(pk_drain), .din(s_data),
    .cap, .keep(pk_keep), .lane(pk_lane), .count(pk_count), .word(pk_word)
  );

  rxr_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_eng (
    .clk, .rst, .rx_en, .ring_base, .ring_cnt, .rel_idx, .idx_clr,
    .s_valid, .s_last, .s_ready,
    .pk_keep, .pk_lane, .pk_count, .pk_word, .pk_clr, .pk_take, .pk_drain,
    .cap_q(cap),
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_gnt, .mem_rvalid, .mem_rdata,
    .cur_idx, .busy
  );
endmodule

// File: tb/sim_rx_ring_dma.sv
module sim_rx_ring_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [7:0]  s_data = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:1023];
  logic        bw_en = 1'b0;
  logic [31:0] bw_addr = '0, bw_data = '0;
  int          cyc = 0;
  int          vectors = 0, errors = 0;

  logic [63:0] wr_q [$];
  string       tag_q [$];
  logic [31:0] rd_q [$];
  logic [63:0] e64;
  logic [31:0] e32;
  string       etag;
  logic        hold_pend = 1'b0;
  logic [31:0] hold_addr = '0;

  always #10 clk = ~clk;

  rx_ring_dma u0 (
    .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .s_valid, .s_data, .s_last, .s_ready,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_gnt, .mem_rvalid, .mem_rdata
  );

  // behavioural memory: grant stalls on a fixed pattern, read data one cycle after grant
  always @(posedge clk) begin
    cyc        <= cyc + 1;
    mem_gnt    <= (cyc % 5) != 3;
    mem_rvalid <= 1'b0;
    if (bw_en) mem[bw_addr[11:2]] <= bw_data;
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[11:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // per-clock comparison of every granted memory transaction against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          if (wr_q.size() == 0) chk(1'b0, "R4 unexpected write", {mem_addr, mem_wdata}, '0);
          else begin
            e64 = wr_q.pop_front();
            etag = tag_q.pop_front();
            chk({mem_addr, mem_wdata} == e64, etag, {mem_addr, mem_wdata}, e64);
          end
        end else begin
          if (rd_q.size() == 0) chk(1'b0, "R3 unexpected read", {32'h0, mem_addr}, '0);
          else begin
            e32 = rd_q.pop_front();
            chk(mem_addr == e32, "R3", {32'h0, mem_addr}, {32'h0, e32});
          end
        end
      end
      if (hold_pend)
        chk(mem_req && mem_addr == hold_addr, "R12", {31'h0, mem_req, mem_addr}, {31'h0, 1'b1, hold_addr});
      hold_pend = mem_req && !mem_gnt;
      hold_addr = mem_addr;
    end
  end

  function automatic logic [7:0] bval(input int seed, input int i);
    return 8'((seed + i * 7) & 255);
  endfunction

  function automatic logic [13:0] lowv(input int slot);
    return 14'(32'h0A0 + slot);
  endfunction

  task automatic bwrite(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bw_en = 1'b1; bw_addr = a; bw_data = d;
    @(negedge clk); bw_en = 1'b0;
  endtask

  task automatic set_desc(input int slot, input int cap);
    bwrite(32'(slot * 16), 32'(32'h400 + slot * 256));
    bwrite(32'(slot * 16 + 4), {2'b00, 14'(cap), 2'b00, lowv(slot)});
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic expect_frame(input int slot, input int n, input int seed, input int cap);
    int m;
    logic [31:0] w, bufa;
    m = (n < cap) ? n : cap;
    bufa = 32'(32'h400 + slot * 256);
    rd_q.push_back(32'(slot * 16));
    rd_q.push_back(32'(slot * 16 + 4));
    for (int k = 0; k < (m + 3) / 4; k++) begin
      w = '0;
      for (int i = 0; i < 4; i++)
        if (4 * k + i < m) w[8*i +: 8] = bval(seed, 4 * k + i);
      wr_q.push_back({bufa + 32'(4 * k), w});
      tag_q.push_back(n > cap ? "R6" : "R4");
    end
    wr_q.push_back({32'(slot * 16 + 4), {2'b11, 14'(m), 2'b00, lowv(slot)}});
    tag_q.push_back(n > cap ? "R6" : "R5");
  endtask

  task automatic push_byte(input logic [7:0] b, input bit last);
    @(negedge clk); s_valid = 1'b1; s_data = b; s_last = last;
    while (!s_ready) @(negedge clk);
    @(posedge clk); #1;
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic send_part(input int n, input int seed, input int from, input int to);
    for (int i = from; i < to; i++) push_byte(bval(seed, i), i == n - 1);
  endtask

  task automatic wait_done();
    int guard;
    guard = 0;
    while ((wr_q.size() != 0 || rd_q.size() != 0) && guard < 3000) begin
      @(negedge clk); guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic quiet_window(input int n, input string rq);
    bit ok;
    ok = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (s_ready || mem_req) ok = 1'b0;
    end
    chk(ok, rq, {62'h0, s_ready, mem_req}, '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] rd;
    for (int s = 0; s < 4; s++) set_desc(s, (s == 1) ? 6 : (s == 3) ? 3 : 64);
    bwrite(32'h508, 32'hDEADBEEF);
    bwrite(32'h704, 32'hCAFEF00D);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk(!s_ready && !mem_req, "R1 ready/req", {62'h0, s_ready, mem_req}, '0);
    reg_read(12'h10C, rd); chk(rd == 0, "R1 index", {32'h0, rd}, 0);
    reg_read(12'h204, rd); chk(rd == 0, "R1 control", {32'h0, rd}, 0);

    // R2 configuration and readback
    reg_write(12'h100, 32'h0);
    reg_write(12'h104, 32'd4);
    reg_write(12'h108, 32'd3);
    reg_write(12'h204, 32'h14);
    reg_read(12'h204, rd); chk(rd == 32'h14, "R2 control", {32'h0, rd}, 64'h14);
    reg_read(12'h104, rd); chk(rd == 4, "R2 size", {32'h0, rd}, 4);
    reg_read(12'h108, rd); chk(rd == 3, "R2 release", {32'h0, rd}, 3);

    // frame A: 10 bytes into slot 0, busy seen mid-frame
    expect_frame(0, 10, 8'h11, 64);
    send_part(10, 8'h11, 0, 3);
    reg_read(12'h204, rd); chk(rd[3] == 1'b1, "R9 busy mid-frame", {32'h0, rd}, 64'h1C);
    send_part(10, 8'h11, 3, 10);
    wait_done();
    reg_read(12'h10C, rd); chk(rd == 1, "R8 index after A", {32'h0, rd}, 1);

    // frame B: 9 bytes into 6-byte slot 1
    expect_frame(1, 9, 8'h30, 6);
    send_part(9, 8'h30, 0, 9);
    wait_done();
    chk(mem[32'h508 >> 2] == 32'hDEADBEEF, "R6 beyond capacity", {32'h0, mem[32'h508 >> 2]}, 64'hDEADBEEF);

    // frame C: exactly one word
    expect_frame(2, 4, 8'h44, 64);
    send_part(4, 8'h44, 0, 4);
    wait_done();
    reg_read(12'h10C, rd); chk(rd == 3, "R8 index after C", {32'h0, rd}, 3);

    // R7 stall at the release index
    @(negedge clk); s_valid = 1'b1; s_data = bval(8'h5A, 0); s_last = 1'b0;
    quiet_window(40, "R7 stall");
    reg_read(12'h204, rd); chk(rd[3] == 1'b0, "R7 busy while stalled", {32'h0, rd}, 64'h14);
    expect_frame(3, 7, 8'h5A, 3);
    reg_write(12'h108, 32'd0);
    send_part(7, 8'h5A, 0, 7);
    wait_done();
    chk(mem[32'h704 >> 2] == 32'hCAFEF00D, "R6 partial word", {32'h0, mem[32'h704 >> 2]}, 64'hCAFEF00D);
    reg_read(12'h10C, rd); chk(rd == 0, "R8 wrap", {32'h0, rd}, 0);
    @(negedge clk); s_valid = 1'b1; s_data = 8'h00;
    quiet_window(10, "R7 stall after wrap");
    s_valid = 1'b0;

    // R10 enable low
    set_desc(0, 64);
    set_desc(1, 64);
    reg_write(12'h108, 32'd3);
    reg_write(12'h204, 32'h10);
    @(negedge clk); s_valid = 1'b1;
    quiet_window(20, "R10 disabled");
    s_valid = 1'b0;
    reg_read(12'h204, rd); chk(rd == 32'h10, "R10 control", {32'h0, rd}, 64'h10);

    // frame E after re-enable
    reg_write(12'h204, 32'h14);
    expect_frame(0, 5, 8'h70, 64);
    send_part(5, 8'h70, 0, 5);
    wait_done();

    // R9 enable cleared mid-frame
    expect_frame(1, 8, 8'h90, 64);
    send_part(8, 8'h90, 0, 2);
    reg_write(12'h204, 32'h10);
    send_part(8, 8'h90, 2, 8);
    wait_done();
    reg_read(12'h204, rd); chk(rd == 32'h10, "R9 idle after finish", {32'h0, rd}, 64'h10);
    reg_read(12'h10C, rd); chk(rd == 2, "R9 index after finish", {32'h0, rd}, 2);
    @(negedge clk); s_valid = 1'b1;
    quiet_window(20, "R10 after finish");
    s_valid = 1'b0;

    // R11 index clear
    reg_write(12'h208, 32'h0);
    reg_read(12'h10C, rd); chk(rd == 2, "R11 no clear", {32'h0, rd}, 2);
    reg_write(12'h208, 32'h0001_0000);
    reg_read(12'h10C, rd); chk(rd == 0, "R11 clear", {32'h0, rd}, 0);

    chk(wr_q.size() == 0 && rd_q.size() == 0, "R4 queue drained",
        64'(wr_q.size() + rd_q.size()), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule